// File: doc/BRIEF.md
# Saturating add/subtract unit

This block forms the sum or the difference of two signed 64-bit operands at full precision and then clamps the outcome into a narrower result range. The result range is `RES_W` bits wide (32 by default), and the clamp can be signed or unsigned. A second operation, saturate-only, skips the arithmetic. It clamps the first operand alone into a range whose width is chosen per operation at run time. The result is returned on a `RES_W`-bit output. A signed result is sign-extended and an unsigned result is zero-extended.

Every accepted operation produces a registered result one cycle later, together with a bit that reports whether clamping took place. A sticky flag gathers those bits across operations and stays set until the `sticky_clr` input is pulsed.

A two-state machine sequences the output. In `ST_IDLE` no result is presented. In `ST_DONE` a result is presented for exactly one cycle. The transition `ACCEPT` (any state to `ST_DONE`) is taken when `in_vld` is high. The transition `DRAIN` (any state to `ST_IDLE`) is taken when `in_vld` is low. Back-to-back strobes keep the machine in `ST_DONE`.

Top module: `satu_top`

## Requirements
- R1: `out_vld` is high in exactly the cycle after each cycle with `in_vld` high, and low otherwise. `out_sat` is low whenever `out_vld` is low. After reset, `out_vld`, `out_sat` and `sticky_sat` are all 0.
- R2: With `sat_only`=0, the intermediate is `op_a+op_b`, or `op_a-op_b` when `sub_en`=1. It is formed without wrap-around: for example, 2^62+2^62 counts as positive. An in-range intermediate appears unchanged in `out_res` with `out_sat`=0.
- R3: Signed arithmetic (`sgn_en`=1, `sat_only`=0) clamps an intermediate above 2^(RES_W-1)-1 to 0x7FFFFFFF and one below -2^(RES_W-1) to 0x80000000, with `out_sat`=1.
- R4: Unsigned arithmetic (`sgn_en`=0, `sat_only`=0) clamps an intermediate of 2^RES_W or more to 0xFFFFFFFF and a negative intermediate to 0, with `out_sat`=1.
- R5: `out_sat` is 1 only when clamping happened. An intermediate that lands exactly on a bound gives that bound with `out_sat`=0.
- R6: Signed saturate-only (`sat_only`=1, `sgn_en`=1) with width w clamps `op_a` into [-2^(w-1), 2^(w-1)-1] and sign-extends the result to `RES_W` bits. `op_b` and `sub_en` have no effect on the result.
- R7: Unsigned saturate-only (`sat_only`=1, `sgn_en`=0) with width w clamps `op_a` into [0, 2^w-1] and zero-extends the result. `out_sat`=1 when either bound was applied.
- R8: A `sat_wid` of 0, or greater than `RES_W`, is treated as `RES_W`. For arithmetic operations `sat_wid` is ignored and the width is always `RES_W`.
- R9: `sticky_sat` is set one cycle after the strobe of any saturating operation. It holds through idle cycles and non-saturating operations, and is cleared in the cycle after a `sticky_clr` pulse.
- R10: When `sticky_clr` and the strobe of a saturating operation fall in the same cycle, `sticky_sat` is 1 afterwards, because setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation strobe |
| op_a | input | 64 | First signed operand (the only operand in saturate-only) |
| op_b | input | 64 | Second signed operand |
| sub_en | input | 1 | 1: subtract op_b, 0: add |
| sgn_en | input | 1 | 1: signed clamp, 0: unsigned clamp |
| sat_only | input | 1 | 1: saturate op_a only, 0: add/subtract |
| sat_wid | input | 6 | Run-time clamp width for saturate-only |
| sticky_clr | input | 1 | Clears the sticky flag |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | Clamped result, sign- or zero-extended |
| out_sat | output | 1 | Clamping occurred for this result |
| sticky_sat | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `in_vld`, `sticky_clr` and the mode selects are known after reset. They also assume that the mode selects captured with a strobe are still readable through `$past` one cycle later, which ties each result class to the mode that produced it. The bench changes every input only on the falling edge and holds the mode fields steady during the capture edge. It covers every mode, including out-of-range widths, with directed values at each clamp bound and one step past it, and then with random operands drawn from both narrow and full-range sets.

// File: rtl/satu_pkg.sv
package satu_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } satu_state_e;

endpackage

// File: rtl/satu_arith.sv
module satu_arith #(
    parameter int OPW = 64,
    parameter int IW  = OPW + 1
) (
    input  logic signed [OPW-1:0] op_a,
    input  logic signed [OPW-1:0] op_b,
    input  logic                  sub_en,
    input  logic                  sat_only,
    output logic signed [IW-1:0]  mid
);
    localparam int EXT = IW - OPW;

    logic signed [IW-1:0] wa, wb;

    always_comb begin
        wa = {{EXT{op_a[OPW-1]}}, op_a};
        wb = {{EXT{op_b[OPW-1]}}, op_b};
        if (sat_only)
            mid = wa;
        else if (sub_en)
            mid = wa - wb;
        else
            mid = wa + wb;
    end
endmodule

// File: rtl/satu_wsel.sv
module satu_wsel #(
    parameter int RES_W = 32,
    parameter int WID_W = $clog2(RES_W + 1)
) (
    input  logic             sat_only,
    input  logic [WID_W-1:0] sat_wid,
    output logic [WID_W-1:0] eff_wid
);
    localparam logic [WID_W-1:0] FULL = WID_W'(RES_W);

    always_comb begin
        if (!sat_only || sat_wid == '0 || sat_wid > FULL)
            eff_wid = FULL;
        else
            eff_wid = sat_wid;
    end
endmodule

// File: rtl/satu_clamp.sv
module satu_clamp #(
    parameter int IW    = 65,
    parameter int RES_W = 32,
    parameter int WID_W = 6
) (
    input  logic signed [IW-1:0] val,
    input  logic [WID_W-1:0]     wid,
    input  logic                 sgn,
    output logic [RES_W-1:0]     res,
    output logic                 sat
);
    localparam logic signed [IW-1:0] ONE = IW'(1);

    logic signed [IW-1:0] hi, lo;

    always_comb begin
        if (sgn) begin
            hi = (ONE << (wid - 1'b1)) - ONE;
            lo = -(ONE << (wid - 1'b1));
        end else begin
            hi = (ONE << wid) - ONE;
            lo = '0;
        end
        sat = 1'b0;
        res = val[RES_W-1:0];
        if (val > hi) begin
            sat = 1'b1;
            res = hi[RES_W-1:0];
        end else if (val < lo) begin
            sat = 1'b1;
            res = lo[RES_W-1:0];
        end
    end
endmodule

// File: rtl/satu_top.sv
module satu_top
    import satu_pkg::*;
#(
    parameter int OPW   = 64,
    parameter int RES_W = 32,
    parameter int WID_W = $clog2(RES_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic signed [OPW-1:0] op_a,
    input  logic signed [OPW-1:0] op_b,
    input  logic                  sub_en,
    input  logic                  sgn_en,
    input  logic                  sat_only,
    input  logic [WID_W-1:0]      sat_wid,
    input  logic                  sticky_clr,
    output logic                  out_vld,
    output logic [RES_W-1:0]      out_res,
    output logic                  out_sat,
    output logic                  sticky_sat
);
    localparam int IW = OPW + 1;

    satu_state_e          state_q, state_d;
    logic signed [IW-1:0] mid;
    logic [WID_W-1:0]     eff_wid;
    logic [RES_W-1:0]     clamp_res;
    logic                 clamp_sat;

    satu_arith #(.OPW(OPW), .IW(IW)) u_arith (
        .op_a     (op_a),
        .op_b     (op_b),
        .sub_en   (sub_en),
        .sat_only (sat_only),
        .mid      (mid)
    );

    satu_wsel #(.RES_W(RES_W), .WID_W(WID_W)) u_wsel (
        .sat_only (sat_only),
        .sat_wid  (sat_wid),
        .eff_wid  (eff_wid)
    );

    satu_clamp #(.IW(IW), .RES_W(RES_W), .WID_W(WID_W)) u_clamp (
        .val (mid),
        .wid (eff_wid),
        .sgn (sgn_en),
        .res (clamp_res),
        .sat (clamp_sat)
    );

    // next state: ACCEPT on a strobe, DRAIN otherwise
    always_comb begin
        state_d = in_vld ? ST_DONE : ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_IDLE: out_vld = 1'b0;
            ST_DONE: out_vld = 1'b1;
            default: out_vld = 1'b0;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_res    <= '0;
            out_sat    <= 1'b0;
            sticky_sat <= 1'b0;
        end else begin
            if (in_vld)
                out_res <= clamp_res;
            out_sat    <= in_vld & clamp_sat;
            sticky_sat <= (sticky_sat & ~sticky_clr) | (in_vld & clamp_sat);
        end
    end
endmodule

// File: rtl/satu_chk.sv
module satu_chk #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             sgn_en,
    input logic             sat_only,
    input logic             sticky_clr,
    input logic             out_vld,
    input logic [RES_W-1:0] out_res,
    input logic             out_sat,
    input logic             sticky_sat
);
    localparam logic [RES_W-1:0] S_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] S_MIN = {1'b1, {(RES_W-1){1'b0}}};

    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r1_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r1_no_sat_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !out_sat);

    a_r3_signed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_sat && $past(sgn_en) && !$past(sat_only))
        |-> (out_res == S_MAX || out_res == S_MIN));

    a_r4_unsigned_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_sat && !$past(sgn_en) && !$past(sat_only))
        |-> (out_res == '0 || out_res == '1));

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_sat) |-> sticky_sat);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_sat && !sticky_clr) |=> sticky_sat);

    a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky_clr) && !(out_vld && out_sat)) |-> !sticky_sat);
endmodule

bind satu_top satu_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .sgn_en     (sgn_en),
    .sat_only   (sat_only),
    .sticky_clr (sticky_clr),
    .out_vld    (out_vld),
    .out_res    (out_res),
    .out_sat    (out_sat),
    .sticky_sat (sticky_sat)
);

// File: tb/tb_satu_top.sv
`timescale 1ns/1ps
module tb_satu_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_vld = 1'b0;
    logic signed [63:0] op_a = '0;
    logic signed [63:0] op_b = '0;
    logic               sub_en = 1'b0;
    logic               sgn_en = 1'b0;
    logic               sat_only = 1'b0;
    logic [5:0]         sat_wid = '0;
    logic               sticky_clr = 1'b0;
    logic               out_vld;
    logic [31:0]        out_res;
    logic               out_sat;
    logic               sticky_sat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        sat;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    satu_top dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .sgn_en(sgn_en), .sat_only(sat_only), .sat_wid(sat_wid),
        .sticky_clr(sticky_clr), .out_vld(out_vld), .out_res(out_res),
        .out_sat(out_sat), .sticky_sat(sticky_sat)
    );

    task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] model(logic signed [63:0] a, logic signed [63:0] b,
                                          bit sub, bit sgn, bit so, int wid);
        logic signed [65:0] v, wa, wb, hi, lo;
        int w;
        w  = (!so || wid == 0 || wid > 32) ? 32 : wid;
        wa = $signed({{2{a[63]}}, a});
        wb = $signed({{2{b[63]}}, b});
        v  = so ? wa : (sub ? wa - wb : wa + wb);
        if (sgn) begin
            hi = (66'sd1 <<< (w - 1)) - 66'sd1;
            lo = -(66'sd1 <<< (w - 1));
        end else begin
            hi = (66'sd1 <<< w) - 66'sd1;
            lo = '0;
        end
        if (v > hi) return {1'b1, hi[31:0]};
        if (v < lo) return {1'b1, lo[31:0]};
        return {1'b0, v[31:0]};
    endfunction

    // driver: one strobe, expected item pushed to the scoreboard
    task automatic send(input logic signed [63:0] a, input logic signed [63:0] b,
                        input bit sub, input bit sgn, input bit so, input int wid,
                        input logic [31:0] eres, input bit esat, input string tag);
        exp_t e;
        op_a = a; op_b = b; sub_en = sub; sgn_en = sgn; sat_only = so;
        sat_wid = 6'(wid); in_vld = 1'b1;
        e.res = eres; e.sat = esat; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic sendm(input logic signed [63:0] a, input logic signed [63:0] b,
                         input bit sub, input bit sgn, input bit so, input int wid,
                         input string tag);
        logic [32:0] m;
        m = model(a, b, sub, sgn, so, wid);
        send(a, b, sub, sgn, so, wid, m[31:0], m[32], tag);
    endtask

    task automatic idle(input int n);
        in_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares results as they appear
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R1 unexpected out_vld", {out_sat, out_res}, 33'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(out_res === e.res && out_sat === e.sat, e.tag,
                    {out_sat, out_res}, {e.sat, e.res});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 33'h0, 33'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_vld === 1'b0 && out_sat === 1'b0 && sticky_sat === 1'b0,
            "R1 reset state", {out_vld, out_sat, sticky_sat}, 33'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 full precision, in range
        send(64'sd5, 64'sd7, 0, 1, 0, 0, 32'd12, 0, "R2 add");
        send(64'sd100, 64'sd250, 1, 1, 0, 0, 32'hFFFF_FF6A, 0, "R2 sub negative");
        send(64'sh0000_0100_0000_0000, 64'shFFFF_FF00_0000_0003, 0, 1, 0, 0, 32'd3, 0, "R2 wide operands");
        send(64'sd10, 64'sd3, 1, 0, 0, 0, 32'd7, 0, "R2 unsigned sub");
        idle(2);
        chk(sticky_sat === 1'b0, "R9 no sticky without saturation", {32'h0, sticky_sat}, 33'h0);

        // R3 signed clamps
        send(64'sh7FFF_FFFF, 64'sd1, 0, 1, 0, 0, 32'h7FFF_FFFF, 1, "R3 signed high");
        send(-64'sh8000_0000, 64'sd1, 1, 1, 0, 0, 32'h8000_0000, 1, "R3 signed low");
        send(64'sh4000_0000_0000_0000, 64'sh4000_0000_0000_0000, 0, 1, 0, 0, 32'h7FFF_FFFF, 1, "R2 R3 no wrap high");
        send(64'sh8000_0000_0000_0000, 64'sd1, 1, 1, 0, 0, 32'h8000_0000, 1, "R2 R3 no wrap low");
        // R5 exact bounds
        send(64'sh7FFF_FFFE, 64'sd1, 0, 1, 0, 0, 32'h7FFF_FFFF, 0, "R5 signed max exact");
        send(-64'sh8000_0000, 64'sd0, 0, 1, 0, 0, 32'h8000_0000, 0, "R5 signed min exact");
        send(64'shFFFF_FFFE, 64'sd1, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, "R5 unsigned max exact");
        send(64'sd4, 64'sd4, 1, 0, 0, 0, 32'h0, 0, "R5 unsigned zero exact");
        // R4 unsigned clamps
        send(64'shFFFF_FFFF, 64'sd1, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, "R4 unsigned high");
        send(64'sd3, 64'sd5, 1, 0, 0, 0, 32'h0, 1, "R4 unsigned negative");
        // R8 arithmetic ignores sat_wid
        send(64'sd300, 64'sd0, 0, 1, 0, 8, 32'd300, 0, "R8 arith ignores sat_wid");
        // R6 signed saturate-only
        send(64'sd200, 64'sd0, 0, 1, 1, 8, 32'h0000_007F, 1, "R6 w8 high");
        send(-64'sd129, 64'sd0, 0, 1, 1, 8, 32'hFFFF_FF80, 1, "R6 w8 low");
        send(-64'sd128, 64'sd0, 0, 1, 1, 8, 32'hFFFF_FF80, 0, "R6 w8 min exact");
        send(64'sd127, 64'sd1000, 1, 1, 1, 8, 32'h0000_007F, 0, "R6 op_b sub_en ignored");
        send(64'sd5, 64'sd0, 0, 1, 1, 1, 32'h0, 1, "R6 w1 high");
        send(-64'sd1, 64'sd0, 0, 1, 1, 1, 32'hFFFF_FFFF, 0, "R6 w1 min exact");
        // R7 unsigned saturate-only
        send(64'sd300, 64'sd0, 0, 0, 1, 8, 32'h0000_00FF, 1, "R7 w8 high");
        send(-64'sd4, 64'sd0, 0, 0, 1, 8, 32'h0, 1, "R7 w8 negative");
        send(64'sd255, 64'sd7, 1, 0, 1, 8, 32'h0000_00FF, 0, "R7 w8 max exact");
        send(64'sh1_0000_0000, 64'sd0, 0, 0, 1, 32, 32'hFFFF_FFFF, 1, "R7 w32 high");
        // R8 out-of-range widths
        send(64'sh8000_0000, 64'sd0, 0, 1, 1, 0, 32'h7FFF_FFFF, 1, "R8 width 0 as 32");
        send(-64'sh8000_0000, 64'sd0, 0, 1, 1, 40, 32'h8000_0000, 0, "R8 width 40 as 32");
        idle(2);

        // R9 sticky hold and clear
        chk(sticky_sat === 1'b1, "R9 sticky set", {32'h0, sticky_sat}, 33'h1);
        send(64'sd1, 64'sd1, 0, 1, 0, 0, 32'd2, 0, "R9 clean op");
        idle(3);
        chk(sticky_sat === 1'b1, "R9 sticky holds", {32'h0, sticky_sat}, 33'h1);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        chk(sticky_sat === 1'b0, "R9 sticky cleared", {32'h0, sticky_sat}, 33'h0);
        send(-64'sd9, 64'sd0, 0, 0, 1, 4, 32'h0, 1, "R9 saturating op");
        idle(1);
        chk(sticky_sat === 1'b1, "R9 sticky set again", {32'h0, sticky_sat}, 33'h1);

        // R10 set wins over clear
        sticky_clr = 1'b1;
        send(64'sd99, 64'sd0, 0, 1, 1, 4, 32'h7, 1, "R10 op with clear");
        sticky_clr = 1'b0;
        idle(1);
        chk(sticky_sat === 1'b1, "R10 set wins", {32'h0, sticky_sat}, 33'h1);

        // mixed random operations through the reference model
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ra, rb;
            logic signed [63:0] a, b;
            ra = $urandom; rb = $urandom;
            if (i % 3 == 0) begin
                a = {$urandom, ra};
                b = {$urandom, rb};
            end else begin
                a = {{32{ra[31]}}, ra};
                b = {{32{rb[31]}}, rb};
            end
            sendm(a, b, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 41), "R2 R5 mixed");
        end
        idle(3);
        chk(sbq.size() == 0, "R1 all results returned", 33'(sbq.size()), 33'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule